// File: doc/BRIEF.md
# Bank-Switched Two-Port Memory

This block gives two independent requesters simultaneous access to one shared word array. The array is not a true two-port memory. It is built from many small single-port banks. The upper bits of each port's word address pick a bank, and the lower bits pick a word inside it. When the two ports name different banks in the same cycle, both accesses go ahead in parallel. When they name the same bank, the block treats this as a collision. Neither access takes effect, and both ports raise a collision flag.

Each port registers its select pair, write strobe, lane enables and write data on the clock edge. The access address does not come straight from the address pins. It comes from a per-port word counter. The counter can take an external address, step forward by one, hold its value, or return to the address it last took. Reads use a two-stage pipeline. Write lanes are 9 bits wide. Both ports share one clock, so a collision is always judged on the two ports' registered bank numbers from the same edge.

Top module: `bank_switch_dpram`

## Requirements
- R1: The word address is split with the upper BANK_W bits as the bank number and the lower OFFS_W bits as the word offset. A word written at an address through one port reads back at the same address through the other port.
- R2: When both ports are selected and their bank numbers differ, both ports' accesses complete in the same cycle.
- R3: When both ports are selected and their bank numbers are equal, no word of the array changes. Two cycles after that sampling edge, both ports show clash high, rvalid low and rdata zero.
- R4: A port is deselected for a cycle when its csn is high or its cs is low. A deselected port writes nothing, and two cycles later it shows rvalid low, clash low and rdata zero.
- R5: A read sampled at clock edge k shows its word on rdata, with rvalid high, after edge k+2.
- R6: Write lane i covers data bits [9i+8:9i] and is enabled by lanes bit i. On a write, only the enabled lanes of the addressed word change.
- R7: A high load takes addr as the access address for that cycle. With load and replay low, a high step sets the access address to the previous one plus one, and a low step keeps the previous address.
- R8: Stepping from the all-ones address gives address zero.
- R9: A high replay with load low returns the access address to the address most recently taken by load. Load has priority over replay, and replay has priority over step.
- R10: Whenever rvalid is low, rdata is zero. This includes write cycles.
- R11: A synchronous active-low reset clears both counters and the last-loaded addresses to zero, deselects both ports and clears rvalid and clash. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| a_csn | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_lanes | input | LANES | Port A write lane enables |
| a_addr | input | BANK_W+OFFS_W | Port A external word address |
| a_wdata | input | DATA_W | Port A write data |
| a_load | input | 1 | Port A take external address |
| a_step | input | 1 | Port A advance counter |
| a_replay | input | 1 | Port A return to last loaded address |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_clash | output | 1 | Port A bank collision flag |
| b_csn | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_lanes | input | LANES | Port B write lane enables |
| b_addr | input | BANK_W+OFFS_W | Port B external word address |
| b_wdata | input | DATA_W | Port B write data |
| b_load | input | 1 | Port B take external address |
| b_step | input | 1 | Port B advance counter |
| b_replay | input | 1 | Port B return to last loaded address |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_clash | output | 1 | Port B bank collision flag |

## Verification
Several properties are checked on every cycle. A collision clears rvalid and raises the flag on both ports two edges later. A deselected port shows nothing two edges later, and a granted read always comes out valid. Read data is zero whenever it is not valid. The counter's hold, wrap and replay moves are also checked each cycle. Other behaviour can only be seen through the bench's scenarios, where a model of the array is compared with read-back data. These are that a blocked write really leaves the array untouched, that only the enabled lanes of a word change, and that data crosses correctly between ports and banks.

// File: rtl/bsdp_pkg.sv
// Shared definitions for the bank-switched two-port memory.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bsdp_pkg;

    // What the per-port word counter does on a clock edge.
    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_STEP   = 2'd1,
        CNT_LOAD   = 2'd2,
        CNT_REPLAY = 2'd3
    } cnt_act_e;

    // Priority: load over replay over step; else hold.
    function automatic cnt_act_e cnt_pick(input logic load, input logic replay,
                                          input logic step);
        if (load)        return CNT_LOAD;
        else if (replay) return CNT_REPLAY;
        else if (step)   return CNT_STEP;
        else             return CNT_HOLD;
    endfunction

endpackage

// File: rtl/bsdp_port_front.sv
// Input register and word counter for one port.
// Each edge samples the select pair, write strobe, lanes and data, and it
// moves the counter by load, replay, step or hold. After the edge, cnt_q is
// the access address of the registered request.
// Assumes a synchronous active-low reset.
module bsdp_port_front
    import bsdp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              cs,
    input  logic              we,
    input  logic [LANES-1:0]  lanes,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic              step,
    input  logic              replay,
    output logic              act_q,
    output logic              we_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [ADDR_W-1:0] cnt_q
);

    logic [ADDR_W-1:0] base_q;
    cnt_act_e          act_sel;

    // Decode the counter move from the strobes.
    always_comb act_sel = cnt_pick(load, replay, step);

    // Register the request controls and the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            we_q    <= 1'b0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else begin
            act_q   <= !csn && cs;
            we_q    <= we;
            lanes_q <= lanes;
            wdata_q <= wdata;
        end
    end

    // Move the word counter and remember the last loaded address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_q <= '0;
        end else begin
            unique case (act_sel)
                CNT_LOAD: begin
                    cnt_q  <= addr;
                    base_q <= addr;
                end
                CNT_REPLAY: cnt_q <= base_q;
                CNT_STEP:   cnt_q <= cnt_q + ADDR_W'(1);
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !replay && !step) |=> $stable(cnt_q));

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !replay && (&cnt_q)) |=> (cnt_q == '0));

    a_r9_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (replay && !load) |=> (cnt_q == $past(base_q)));

endmodule

// File: rtl/bsdp_bank.sv
// One single-port storage bank with per-lane write enables.
// When en is high, a write changes only the enabled lanes, and a read loads
// the addressed word into a registered output. That output keeps its value
// until the next read of this bank. The contents are not reset.
// Assumes at most one port drives this bank in any cycle.
module bsdp_bank #(
    parameter int OFFS_W = 4,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [LANES-1:0]  lanes,
    input  logic [OFFS_W-1:0] offs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH  = 1 << OFFS_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write only the enabled lanes of the addressed word.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (en && we && lanes[i])
                mem[offs][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    // Register the read word (pipeline stage one).
    always_ff @(posedge clk) begin
        if (en && !we)
            rdata <= mem[offs];
    end

endmodule

// File: rtl/bsdp_read_stage.sv
// Second half of one port's read pipeline.
// Stage one records whether a read was granted, which bank it used and
// whether a collision occurred. Stage two picks that bank's registered word
// and gives zero when the read is not valid.
// Assumes a synchronous active-low reset.
module bsdp_read_stage #(
    parameter int BANK_W = 3,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              clash_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [DATA_W-1:0] bank_dout [1 << BANK_W],
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              clash
);

    logic              rd1_q;
    logic              clash1_q;
    logic [BANK_W-1:0] bank1_q;

    // Stage one: remember the granted read and its bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd1_q    <= 1'b0;
            clash1_q <= 1'b0;
            bank1_q  <= '0;
        end else begin
            rd1_q    <= rd_req;
            clash1_q <= clash_in;
            bank1_q  <= bank_in;
        end
    end

    // Stage two: present the word, or zero when it is not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            clash  <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd1_q;
            clash  <= clash1_q;
            rdata  <= rd1_q ? bank_dout[bank1_q] : '0;
        end
    end

    a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

endmodule

// File: rtl/bank_switch_dpram.sv
// Two-port memory built from 2**BANK_W single-port banks.
// Each port's counter gives its access address. The upper BANK_W bits pick
// a bank. A same-bank request by two selected ports blocks both of them and
// is flagged on both ports. Otherwise each bank is driven by the port that
// picked it. Read data comes out two edges after the request is sampled.
// Assumes both ports share one clock and a synchronous active-low reset.
module bank_switch_dpram #(
    parameter int BANK_W = 3,
    parameter int OFFS_W = 4,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_csn,
    input  logic                     a_cs,
    input  logic                     a_we,
    input  logic [LANES-1:0]         a_lanes,
    input  logic [BANK_W+OFFS_W-1:0] a_addr,
    input  logic [DATA_W-1:0]        a_wdata,
    input  logic                     a_load,
    input  logic                     a_step,
    input  logic                     a_replay,
    output logic [DATA_W-1:0]        a_rdata,
    output logic                     a_rvalid,
    output logic                     a_clash,
    input  logic                     b_csn,
    input  logic                     b_cs,
    input  logic                     b_we,
    input  logic [LANES-1:0]         b_lanes,
    input  logic [BANK_W+OFFS_W-1:0] b_addr,
    input  logic [DATA_W-1:0]        b_wdata,
    input  logic                     b_load,
    input  logic                     b_step,
    input  logic                     b_replay,
    output logic [DATA_W-1:0]        b_rdata,
    output logic                     b_rvalid,
    output logic                     b_clash
);

    localparam int ADDR_W = BANK_W + OFFS_W;
    localparam int NBANKS = 1 << BANK_W;

    logic              a_act, a_wq, b_act, b_wq;
    logic [LANES-1:0]  a_lq, b_lq;
    logic [DATA_W-1:0] a_dq, b_dq;
    logic [ADDR_W-1:0] a_cnt, b_cnt;
    logic [BANK_W-1:0] a_bank, b_bank;
    logic [OFFS_W-1:0] a_offs, b_offs;
    logic              clash_now, a_grant, b_grant;
    logic [DATA_W-1:0] dout [NBANKS];

    bsdp_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_a (
        .clk(clk), .rst_n(rst_n), .csn(a_csn), .cs(a_cs), .we(a_we),
        .lanes(a_lanes), .addr(a_addr), .wdata(a_wdata), .load(a_load),
        .step(a_step), .replay(a_replay), .act_q(a_act), .we_q(a_wq),
        .lanes_q(a_lq), .wdata_q(a_dq), .cnt_q(a_cnt));

    bsdp_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_b (
        .clk(clk), .rst_n(rst_n), .csn(b_csn), .cs(b_cs), .we(b_we),
        .lanes(b_lanes), .addr(b_addr), .wdata(b_wdata), .load(b_load),
        .step(b_step), .replay(b_replay), .act_q(b_act), .we_q(b_wq),
        .lanes_q(b_lq), .wdata_q(b_dq), .cnt_q(b_cnt));

    // Split each access address into bank and word offset.
    always_comb begin
        a_bank = a_cnt[ADDR_W-1 -: BANK_W];
        b_bank = b_cnt[ADDR_W-1 -: BANK_W];
        a_offs = a_cnt[OFFS_W-1:0];
        b_offs = b_cnt[OFFS_W-1:0];
    end

    // Detect a same-bank collision and grant only when there is none.
    always_comb begin
        clash_now = a_act && b_act && (a_bank == b_bank);
        a_grant   = a_act && !clash_now;
        b_grant   = b_act && !clash_now;
    end

    for (genvar bk = 0; bk < NBANKS; bk++) begin : g_bank
        logic              sel_a, sel_b, en, we;
        logic [LANES-1:0]  lanes;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] wdata;

        // Route the granted port, if any, to this bank.
        always_comb begin
            sel_a = a_grant && (a_bank == BANK_W'(bk));
            sel_b = b_grant && (b_bank == BANK_W'(bk));
            en    = sel_a || sel_b;
            we    = sel_a ? a_wq : b_wq;
            lanes = sel_a ? a_lq : b_lq;
            offs  = sel_a ? a_offs : b_offs;
            wdata = sel_a ? a_dq : b_dq;
        end

        bsdp_bank #(.OFFS_W(OFFS_W), .DATA_W(DATA_W), .LANES(LANES)) u_bank (
            .clk(clk), .en(en), .we(we), .lanes(lanes), .offs(offs),
            .wdata(wdata), .rdata(dout[bk]));

        a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel_a && sel_b));
    end

    bsdp_read_stage #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .rd_req(a_grant && !a_wq),
        .clash_in(clash_now), .bank_in(a_bank), .bank_dout(dout),
        .rdata(a_rdata), .rvalid(a_rvalid), .clash(a_clash));

    bsdp_read_stage #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .rd_req(b_grant && !b_wq),
        .clash_in(clash_now), .bank_in(b_bank), .bank_dout(dout),
        .rdata(b_rdata), .rvalid(b_rvalid), .clash(b_clash));

    a_r3_clash_both: assert property (@(posedge clk) disable iff (!rst_n)
        clash_now |=> ##1 (a_clash && b_clash && !a_rvalid && !b_rvalid));

    a_r4_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_act |=> ##1 (!a_rvalid && !a_clash));

    a_r4_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_act |=> ##1 (!b_rvalid && !b_clash));

    a_r5_latency_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_grant && !a_wq) |=> ##1 a_rvalid);

    a_r5_latency_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_grant && !b_wq) |=> ##1 b_rvalid);

endmodule

// File: tb/bank_switch_dpram_test.sv
module bank_switch_dpram_test;

    localparam int BANK_W = 3;
    localparam int OFFS_W = 4;
    localparam int DATA_W = 36;
    localparam int LANES  = 4;
    localparam int ADDR_W = BANK_W + OFFS_W;
    localparam int WORDS  = 1 << ADDR_W;

    typedef struct {
        bit              csn, cs, we, load, step, replay;
        bit [LANES-1:0]  lanes;
        bit [ADDR_W-1:0] addr;
        bit [DATA_W-1:0] wd;
    } pin_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_csn = 1'b1, a_cs = 1'b0, a_we = 1'b0, a_load = 1'b0, a_step = 1'b0, a_replay = 1'b0;
    logic b_csn = 1'b1, b_cs = 1'b0, b_we = 1'b0, b_load = 1'b0, b_step = 1'b0, b_replay = 1'b0;
    logic [LANES-1:0]  a_lanes = '0, b_lanes = '0;
    logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
    logic [DATA_W-1:0] a_wdata = '0, b_wdata = '0;
    logic [DATA_W-1:0] a_rdata, b_rdata;
    logic              a_rvalid, b_rvalid, a_clash, b_clash;

    int checks = 0;
    int errors = 0;

    bit [DATA_W-1:0] mdl [WORDS];
    bit [ADDR_W-1:0] mcnt [2];
    bit [ADDR_W-1:0] mbase [2];
    bit              ev [3][2];
    bit              ec [3][2];
    bit [DATA_W-1:0] ed [3][2];
    string           et [3][2];
    bit              checking = 1'b0;

    always #4 clk = ~clk;

    bank_switch_dpram #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_csn(a_csn), .a_cs(a_cs), .a_we(a_we), .a_lanes(a_lanes), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_load(a_load), .a_step(a_step), .a_replay(a_replay),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_clash(a_clash),
        .b_csn(b_csn), .b_cs(b_cs), .b_we(b_we), .b_lanes(b_lanes), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_load(b_load), .b_step(b_step), .b_replay(b_replay),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_clash(b_clash));

    function automatic pin_t p_idle();
        pin_t p;
        p.csn = 1; p.cs = 0; p.we = 0; p.load = 0; p.step = 0; p.replay = 0;
        p.lanes = '0; p.addr = '0; p.wd = '0;
        return p;
    endfunction

    function automatic pin_t p_rd(bit load, bit [ADDR_W-1:0] addr);
        pin_t p = p_idle();
        p.csn = 0; p.cs = 1; p.load = load; p.addr = addr;
        return p;
    endfunction

    function automatic pin_t p_wr(bit [ADDR_W-1:0] addr, bit [DATA_W-1:0] wd,
                                  bit [LANES-1:0] lanes);
        pin_t p = p_rd(1'b1, addr);
        p.we = 1; p.wd = wd; p.lanes = lanes;
        return p;
    endfunction

    // Lane i holds bits [9i+8:9i]; merge only enabled lanes (R6).
    function automatic bit [DATA_W-1:0] merge(bit [DATA_W-1:0] old, bit [DATA_W-1:0] nw,
                                              bit [LANES-1:0] ln);
        bit [DATA_W-1:0] r = old;
        for (int i = 0; i < LANES; i++)
            if (ln[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    function automatic bit [ADDR_W-1:0] next_cnt(int p, pin_t pp);
        if (pp.load) return pp.addr;
        if (pp.replay) return mbase[p];
        if (pp.step) return mcnt[p] + 1'b1;
        return mcnt[p];
    endfunction

    task automatic check_outs();
        bit              gv[2], gc[2];
        bit [DATA_W-1:0] gd[2];
        gv[0] = a_rvalid; gc[0] = a_clash; gd[0] = a_rdata;
        gv[1] = b_rvalid; gc[1] = b_clash; gd[1] = b_rdata;
        for (int p = 0; p < 2; p++) begin
            checks++;
            if (gv[p] !== ev[2][p] || gc[p] !== ec[2][p] || gd[p] !== ed[2][p]) begin
                errors++;
                $display("FAIL %s port %0d: got v=%0b c=%0b d=%h exp v=%0b c=%0b d=%h",
                         et[2][p], p, gv[p], gc[p], gd[p], ev[2][p], ec[2][p], ed[2][p]);
            end
        end
    endtask

    task automatic apply(pin_t pa, pin_t pb);
        a_csn = pa.csn; a_cs = pa.cs; a_we = pa.we; a_lanes = pa.lanes; a_addr = pa.addr;
        a_wdata = pa.wd; a_load = pa.load; a_step = pa.step; a_replay = pa.replay;
        b_csn = pb.csn; b_cs = pb.cs; b_we = pb.we; b_lanes = pb.lanes; b_addr = pb.addr;
        b_wdata = pb.wd; b_load = pb.load; b_step = pb.step; b_replay = pb.replay;
    endtask

    task automatic tick(pin_t pa, pin_t pb, string tag);
        pin_t            pp[2];
        bit              act[2];
        bit              clash;
        bit [ADDR_W-1:0] ad[2];
        pp[0] = pa; pp[1] = pb;
        @(negedge clk);
        if (checking) check_outs();
        for (int p = 0; p < 2; p++) begin
            ev[2][p] = ev[1][p]; ec[2][p] = ec[1][p]; ed[2][p] = ed[1][p]; et[2][p] = et[1][p];
            ev[1][p] = ev[0][p]; ec[1][p] = ec[0][p]; ed[1][p] = ed[0][p]; et[1][p] = et[0][p];
        end
        apply(pa, pb);
        for (int p = 0; p < 2; p++) begin
            mcnt[p] = next_cnt(p, pp[p]);
            if (pp[p].load) mbase[p] = pp[p].addr;
            ad[p]  = mcnt[p];
            act[p] = !pp[p].csn && pp[p].cs;
        end
        clash = act[0] && act[1] && (ad[0][ADDR_W-1 -: BANK_W] == ad[1][ADDR_W-1 -: BANK_W]);
        for (int p = 0; p < 2; p++) begin
            ev[0][p] = act[p] && !clash && !pp[p].we;
            ec[0][p] = clash;
            ed[0][p] = ev[0][p] ? mdl[ad[p]] : '0;
            et[0][p] = clash ? {tag, " R3"} : !act[p] ? {tag, " R4"} :
                       pp[p].we ? {tag, " R10"} : {tag, " R5"};
        end
        for (int p = 0; p < 2; p++)
            if (act[p] && !clash && pp[p].we)
                mdl[ad[p]] = merge(mdl[ad[p]], pp[p].wd, pp[p].lanes);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        apply(p_idle(), p_idle());
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            mcnt[p] = '0; mbase[p] = '0;
            for (int s = 0; s < 3; s++) begin
                ev[s][p] = 0; ec[s][p] = 0; ed[s][p] = '0; et[s][p] = "R11";
            end
        end
        rst_n = 1'b1;
    endtask

    task automatic flush();
        repeat (3) tick(p_idle(), p_idle(), "flush R4");
    endtask

    function automatic pin_t p_rand();
        pin_t p = p_idle();
        p.csn    = ($urandom % 8) == 0;
        p.cs     = ($urandom % 8) != 0;
        p.we     = $urandom % 2;
        p.load   = $urandom % 2;
        p.replay = ($urandom % 6) == 0;
        p.step   = $urandom % 2;
        p.lanes  = LANES'($urandom);
        p.addr   = ADDR_W'($urandom);
        p.wd     = {4'($urandom), 32'($urandom)};
        return p;
    endfunction

    initial begin
        pin_t pa, pb;
        void'($urandom(32'd20240607));
        do_reset();
        checking = 1'b1;
        // Fill every word; ports always in different banks (R2).
        for (int i = 0; i < WORDS / 2; i++)
            tick(p_wr(ADDR_W'(i), {4'h3, 32'(i * 32'h01010101)}, '1),
                 p_wr(ADDR_W'(i + WORDS / 2), {4'hC, 32'(i * 32'h10203)}, '1), "init R2");
        flush();
        // Counters clear on reset, memory kept (R11).
        do_reset();
        tick(p_rd(0, '0), p_idle(), "R11 counter zero");
        flush();
        // Bank 2 offset 5 = address 0x25 crosses ports (R1).
        tick(p_wr(7'h25, 36'h9_1234_5678, '1), p_rd(1, 7'h50), "R1 R2 write+read");
        tick(p_idle(), p_rd(1, 7'h25), "R1 cross read");
        // Same bank 3 from both ports: blocked writes (R3).
        tick(p_wr(7'h31, 36'hA_AAAA_AAAA, '1), p_wr(7'h3A, 36'h5_5555_5555, '1), "R3 clash write");
        tick(p_rd(1, 7'h31), p_rd(1, 7'h6A), "R3 readback");
        tick(p_rd(1, 7'h12), p_rd(1, 7'h3A), "R3 readback");
        tick(p_rd(1, 7'h34), p_rd(1, 7'h30), "R3 clash read");
        // Deselected writes do nothing (R4).
        pa = p_wr(7'h44, 36'hF_0F0F_0F0F, '1); pa.csn = 1;
        pb = p_wr(7'h55, 36'hF_0F0F_0F0F, '1); pb.cs = 0;
        tick(pa, pb, "R4 deselect write");
        tick(p_rd(1, 7'h44), p_rd(1, 7'h55), "R4 readback");
        // Lane mask 0101 (R6).
        tick(p_wr(7'h66, 36'hF_FFFF_FFFF, 4'b0101), p_idle(), "R6 lanes");
        tick(p_rd(1, 7'h66), p_idle(), "R6 readback");
        // Load, step, hold (R7).
        tick(p_rd(1, 7'h10), p_rd(1, 7'h70), "R7 load");
        pa = p_rd(0, '0); pa.step = 1;
        tick(pa, pa, "R7 step");
        tick(p_rd(0, '0), p_rd(0, '0), "R7 hold");
        // Wrap from all ones (R8).
        tick(p_rd(1, 7'h7F), p_idle(), "R8 top");
        tick(pa, p_idle(), "R8 wrap");
        // Replay and priority (R9).
        tick(p_rd(1, 7'h2C), p_idle(), "R9 load");
        tick(pa, p_idle(), "R9 step");
        pb = p_rd(0, '0); pb.replay = 1; pb.step = 1;
        tick(pb, p_idle(), "R9 replay");
        pb = p_rd(1, 7'h0B); pb.replay = 1;
        tick(pb, p_idle(), "R9 load wins");
        flush();
        // Random traffic with forced bank collisions.
        for (int n = 0; n < 600; n++) begin
            pa = p_rand(); pb = p_rand();
            if (($urandom % 3) == 0) pb.addr[ADDR_W-1 -: BANK_W] = pa.addr[ADDR_W-1 -: BANK_W];
            tick(pa, pb, "rand");
        end
        flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule